// File: doc/BRIEF.md
# Thermal Trip Latch Controller

This block turns an over-temperature flag from an on-die comparator into an active-low thermal-trip output and a request to stop the internal clocks. The output is driven only after power-good has been high for a qualification delay. A trip is latched. Only a drop of power-good clears it. If the die is still hot when power-good returns, the trip is raised again as soon as the output is enabled.

The block is built around a four-state machine:
- `ST_OFF`: power-good is low; all state is held cleared.
- `ST_QUAL`: the qualification timer runs.
- `ST_ARMED`: the output is driven high and the synchronized flag is watched.
- `ST_TRIP`: the trip is latched and the clock-halt request is raised.

The transitions are:
- `OFF->QUAL`: the first clock edge with power-good high.
- `QUAL->ARMED`: the edge on which the timer reports that `QUAL_CYCLES` cycles have elapsed.
- `ARMED->TRIP`: an edge that sees the synchronized flag high.
- `TRIP` holds until power-good falls.
- A fall of power-good returns every state to `OFF` at once, without waiting for a clock edge.

The over-temperature flag crosses into the clock domain through a two-flop synchronizer.

Top module: `thermal_trip_ctrl`

## Requirements
- R1: While `pwr_ok` is 0, `trip_n` is 1, `trip_oe` is 0 and `halt_req` is 0. This takes effect as soon as `pwr_ok` falls, without waiting for a clock edge.
- R2: Number the rising clock edges 1, 2, … from the first edge with `pwr_ok` high. `trip_oe` becomes 1 after edge `QUAL_CYCLES`+1 and is 0 before it.
- R3: Until `trip_oe` is 1, `over_temp` has no effect: `trip_n` stays 1 and `halt_req` stays 0.
- R4: `over_temp` passes through two flops. If `over_temp` is 1 when sampled at edge k, and `trip_oe` is 1 before edge k+2, then `trip_n` is 0 after edge k+2.
- R5: Once `trip_n` is 0, it stays 0 until `pwr_ok` falls, whatever `over_temp` does.
- R6: `halt_req` is 1 exactly when a trip is latched, that is, when `trip_n` is 0.
- R7: If `over_temp` is held at 1 from edge `QUAL_CYCLES`-1 onward, `trip_n` falls after edge `QUAL_CYCLES`+2. This is the first edge after enable.
- R8: Once `trip_oe` is 1, it stays 1 until `pwr_ok` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_ok | input | 1 | Power-good; low clears all state asynchronously |
| over_temp | input | 1 | Asynchronous over-temperature flag from the comparator |
| trip_n | output | 1 | Active-low thermal-trip value |
| trip_oe | output | 1 | Output enable for `trip_n`; when low the pad floats to its pull-up |
| halt_req | output | 1 | Request to stop the internal clocks |

## Verification
The assertions assume that `pwr_ok` falls only between clock edges and rises only at a negative clock edge. They also assume that `over_temp` changes only between edges. This makes the three-edge latency from flag to trip exact rather than one edge uncertain. The bench drives every input at the falling clock edge. It drops `pwr_ok` part-way through a low clock phase, and it sweeps the start and width of the flag pulse across the whole qualification window and beyond it.

// File: rtl/trip_pkg.sv
package trip_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_QUAL  = 2'd1,
        ST_ARMED = 2'd2,
        ST_TRIP  = 2'd3
    } trip_state_t;
endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/trip_qual_timer.sv
module trip_qual_timer #(
    parameter int QUAL_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (QUAL_CYCLES < 2) ? 1 : $clog2(QUAL_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count <= '0;
        else if (!run)           count <= '0;
        else if (count != LAST)  count <= count + 1'b1;
    end

    assign done = run && (count == LAST);
endmodule

// File: rtl/thermal_trip_ctrl.sv
module thermal_trip_ctrl
    import trip_pkg::*;
#(
    parameter int QUAL_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic over_temp,
    output logic trip_n,
    output logic trip_oe,
    output logic halt_req
);
    trip_state_t state, state_nx;
    logic        hot_s;
    logic        qual_done;

    trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (pwr_ok),
        .d_async (over_temp),
        .q_sync  (hot_s)
    );

    trip_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (pwr_ok),
        .run   (state == ST_QUAL),
        .done  (qual_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   state_nx = ST_QUAL;
            ST_QUAL:  if (qual_done) state_nx = ST_ARMED;
            ST_ARMED: if (hot_s)     state_nx = ST_TRIP;
            ST_TRIP:  state_nx = ST_TRIP;
            default:  state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) state <= ST_OFF;
        else         state <= state_nx;
    end

    always_comb begin
        trip_n   = 1'b1;
        trip_oe  = 1'b0;
        halt_req = 1'b0;
        unique case (state)
            ST_OFF, ST_QUAL: ;
            ST_ARMED: trip_oe = 1'b1;
            ST_TRIP: begin
                trip_oe  = 1'b1;
                trip_n   = 1'b0;
                halt_req = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/thermal_trip_ctrl_chk.sv
module thermal_trip_ctrl_chk #(
    parameter int QUAL_CYCLES = 1000
) (
    input logic clk,
    input logic pwr_ok,
    input logic over_temp,
    input logic trip_n,
    input logic trip_oe,
    input logic halt_req
);
    int unsigned since_up;

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok)                  since_up <= 0;
        else if (since_up < 32'hFFFF) since_up <= since_up + 1;
    end

    // R1
    a_r1_quiet_when_down: assert property (@(posedge clk)
        !pwr_ok |-> (trip_n && !trip_oe && !halt_req));

    // R2
    a_r2_enable_timing: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(trip_oe) |-> (since_up == QUAL_CYCLES + 1));

    // R3
    a_r3_no_trip_unenabled: assert property (@(posedge clk) disable iff (!pwr_ok)
        !trip_n |-> trip_oe);

    // R4
    a_r4_trip_needs_flag: assert property (@(posedge clk) disable iff (!pwr_ok)
        $fell(trip_n) |-> $past(over_temp, 3));

    // R5
    a_r5_latched: assert property (@(posedge clk) disable iff (!pwr_ok)
        !trip_n |=> !trip_n);

    // R6
    a_r6_halt_follows_trip: assert property (@(posedge clk) disable iff (!pwr_ok)
        halt_req == !trip_n);

    // R8
    a_r8_enable_held: assert property (@(posedge clk) disable iff (!pwr_ok)
        trip_oe |=> trip_oe);
endmodule

bind thermal_trip_ctrl thermal_trip_ctrl_chk #(.QUAL_CYCLES(QUAL_CYCLES)) u_chk (
    .clk       (clk),
    .pwr_ok    (pwr_ok),
    .over_temp (over_temp),
    .trip_n    (trip_n),
    .trip_oe   (trip_oe),
    .halt_req  (halt_req)
);

// File: tb/thermal_trip_ctrl_test.sv
`timescale 1ns/1ps
module thermal_trip_ctrl_test;
    localparam int N = 8;

    logic clk = 1'b0;
    logic pwr_ok = 1'b1;
    logic over_temp = 1'b0;
    logic trip_n, trip_oe, halt_req;
    int   errors = 0;
    int   checks = 0;

    always #10 clk = ~clk;

    thermal_trip_ctrl #(.QUAL_CYCLES(N)) uut (
        .clk       (clk),
        .pwr_ok    (pwr_ok),
        .over_temp (over_temp),
        .trip_n    (trip_n),
        .trip_oe   (trip_oe),
        .halt_req  (halt_req)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic power_down();
        #3 pwr_ok = 1'b0;
        #1;
        check(trip_n, 1'b1, "R1", "trip_n async");
        check(trip_oe, 1'b0, "R1", "trip_oe async");
        check(halt_req, 1'b0, "R1", "halt_req async");
        over_temp = 1'b0;
        repeat (2) @(negedge clk);
        check(trip_n, 1'b1, "R1", "trip_n held");
        check(trip_oe, 1'b0, "R1", "trip_oe held");
    endtask

    // flag high when sampled at edges o .. o+len-1
    task automatic run_case(input int o, input int len);
        int t;
        int last;
        t = (o + 2 > N + 2) ? o + 2 : N + 2;
        if (t > o + len + 1) t = 1 << 20;
        last = N + o + len + 4;
        @(negedge clk);
        pwr_ok = 1'b1;
        for (int k = 1; k <= last; k++) begin
            over_temp = (k >= o) && (k <= o + len - 1);
            @(posedge clk);
            @(negedge clk);
            check(trip_oe, (k >= N + 1), (k >= N + 1) ? "R8" : "R2", "trip_oe");
            if (k <= N + 1)
                check(trip_n, 1'b1, "R3", "trip_n before enable");
            else if (k >= t + 1)
                check(trip_n, 1'b0, "R5", "trip_n latched");
            else if (o <= N - 1 && len > N)
                check(trip_n, !(k >= t), "R7", "trip_n persistent flag");
            else
                check(trip_n, !(k >= t), "R4", "trip_n latency");
            check(halt_req, (k >= t), "R6", "halt_req");
        end
        power_down();
    endtask

    initial begin
        #5 pwr_ok = 1'b0;
        @(negedge clk);
        check(trip_n, 1'b1, "R1", "reset trip_n");
        check(trip_oe, 1'b0, "R1", "reset trip_oe");
        check(halt_req, 1'b0, "R1", "reset halt_req");
        for (int o = 1; o <= N + 4; o++) begin
            run_case(o, 1);
            run_case(o, 2);
            run_case(o, N + 10);
        end
        run_case(N + 30, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule